// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models the write-command front end of a small parallel NOR flash device. A register-backed array of 16-bit words holds the stored data. Host writes are not plain stores. Each operation is keyed by a short sequence of bus writes: two unlock cycles, then a command code. A cycle that does not fit the expected pattern silently puts the interpreter back into plain array reading.

Three operations are supported.
- A reset command returns the device to array reading.
- An identification mode returns the maker code, the device code and a protection flag for each sector.
- A word or byte program operation runs for a fixed number of clock cycles.

During a program operation the ready output is low, and any read returns a status byte instead of array data. Programming can only clear bits. A request that needs a 0 turned back into a 1 ends in a sticky error, and only the reset command clears it.

The bus is synchronous. A write strobe and a read strobe are sampled on the rising clock edge. The `byte_n` input selects word addressing (1) or byte addressing (0). In byte mode, `addr[0]` selects the high byte (1) or the low byte (0) of a word, and the word index is taken from `addr` shifted right by one.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset, `ready_o` is 1, the interpreter is in array-read mode and every word of the array reads 16'hFFFF.
- R2: A read strobe loads `rdata` at that clock edge; at all other edges `rdata` holds its value. In array-read mode the value depends on the addressing mode:
  - Word mode returns the word at index `addr[IDX_W-1:0]`.
  - Byte mode returns 8'h00 in the upper byte and, in the lower byte, the byte selected by `addr[0]` of word `addr[IDX_W:1]`.
- R3: Sequences are accepted only in the key order shown below. Any write whose low data byte or compared address differs from the expected key drops the interpreter to array-read mode, and no operation starts.
  - The first key is data AAh at address 555h in word mode (bits [10:0] compared), or at AAAh in byte mode (bits [11:0] compared).
  - The second key is data 55h at address 2AAh in word mode, or at 555h in byte mode.
  - The third cycle must again use the first key's address.
- R4: A write with low data byte F0h returns the interpreter to array-read mode from any address. It is honoured after either unlock write, in identification mode and in the error state.
- R5: Writing the two unlock keys and then command 90h enters identification mode. Reads stay in that mode for any number of accesses, and writes other than F0h are ignored there.
- R6: In identification mode the read result depends on a code offset. In word mode the offset is `addr[1:0]`; in byte mode it is `addr[2:0]`. Byte mode returns only the low byte of each code.
  - Word offset 0, or byte offset 0, returns the maker code.
  - Word offset 1, or byte offset 2, returns the device code.
  - Word offset 2, or byte offset 4, returns the protection flag.
  - Any other offset returns 0.
- R7: The protection flag reads 1 when bit `s` of parameter `PROT_MAP` is set, and 0 otherwise. The sector `s` is the top log2(NSECT) bits of the word index.
- R8: After the two unlock keys and command A0h, the next write starts programming at its address with its data. `ready_o` is low for exactly `PROG_CYC` clock cycles, starting at that edge. The addressed word then reads as the old value AND the new data.
- R9: While programming, a read returns a status byte with the upper byte of `rdata` 0:
  - Bit 7 is the complement of bit 7 of the written data.
  - Bit 6 is 0 on the first read after the start and inverts on each later read.
  - Bit 5 is the failure flag.
  - Bits 4 to 0 are 0.
- R10: While programming, every write is ignored, including F0h.
- R11: When the program data has a 1 where the stored bit is 0, the operation fails. Bit 5 of the status reads 1. After the timed operation `ready_o` stays low and status reads continue until an F0h write. The stored word still becomes the AND of the old value and the new data.
- R12: In byte mode, programming changes only the addressed byte lane. The other byte of the word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| rd_en | input | 1 | Read strobe, sampled on the clock edge |
| addr | input | AW | Word address (word mode) or byte address (byte mode) |
| wdata | input | 16 | Write data; commands use bits [7:0] |
| byte_n | input | 1 | 1 selects word addressing, 0 selects byte addressing |
| rdata | output | 16 | Registered read result |
| ready_o | output | 1 | 1 when ready, 0 while programming or in the error state |

## Verification
The bound checker checks several properties on every cycle:
- the read result holds between read strobes;
- a wrong second unlock cycle falls back to reading;
- the fourth program cycle always drops the ready output;
- the busy state survives every write until the timer ends it;
- identification mode and the error state persist until an F0h write;
- the unused status bits stay zero.

Only the bench scenarios can show the data outcomes. These are the AND-only array contents, the status toggle sequence and its inverted bit 7, the exact busy length, the identification codes for each offset and sector in both addressing modes, and the byte-lane isolation.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

   typedef enum logic [2:0] {
      ST_READ = 3'd0,
      ST_UNL1 = 3'd1,
      ST_UNL2 = 3'd2,
      ST_AUTO = 3'd3,
      ST_PSET = 3'd4,
      ST_BUSY = 3'd5,
      ST_ERR  = 3'd6
   } nfc_state_e;

   typedef enum logic [1:0] {
      ID_MFR  = 2'd0,
      ID_DEV  = 2'd1,
      ID_PROT = 2'd2,
      ID_NONE = 2'd3
   } nfc_id_e;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_PROG    = 8'hA0;
   localparam logic [7:0] OP_RESET   = 8'hF0;

   localparam int WORD_KEY_W = 11;
   localparam int BYTE_KEY_W = 12;
   localparam logic [WORD_KEY_W-1:0] WKEY_A = 11'h555;
   localparam logic [WORD_KEY_W-1:0] WKEY_B = 11'h2AA;
   localparam logic [BYTE_KEY_W-1:0] BKEY_A = 12'hAAA;
   localparam logic [BYTE_KEY_W-1:0] BKEY_B = 12'h555;

   localparam int DATA_W = 16;

endpackage

// File: rtl/nfc_addr_map.sv
module nfc_addr_map
   import nfc_pkg::*;
#(
   parameter int AW      = 12,
   parameter int IDX_W   = 8,
   parameter bit BYTE_OK = 1'b1
) (
   input  logic [AW-1:0]    addr,
   input  logic             byte_n,
   output logic [IDX_W-1:0] widx,
   output logic             lane_hi,
   output logic             word_mode,
   output logic             key_a,
   output logic             key_b,
   output nfc_id_e          id_sel
);

   logic [IDX_W-1:0] w_idx;
   logic             w_ka;
   logic             w_kb;
   nfc_id_e          w_id;

   always_comb begin
      w_idx = addr[IDX_W-1:0];
      w_ka  = (addr[WORD_KEY_W-1:0] == WKEY_A);
      w_kb  = (addr[WORD_KEY_W-1:0] == WKEY_B);
      case (addr[1:0])
         2'd0:    w_id = ID_MFR;
         2'd1:    w_id = ID_DEV;
         2'd2:    w_id = ID_PROT;
         default: w_id = ID_NONE;
      endcase
   end

   generate
      if (BYTE_OK) begin : g_dual
         always_comb begin
            if (byte_n) begin
               widx      = w_idx;
               lane_hi   = 1'b0;
               word_mode = 1'b1;
               key_a     = w_ka;
               key_b     = w_kb;
               id_sel    = w_id;
            end else begin
               widx      = addr[IDX_W:1];
               lane_hi   = addr[0];
               word_mode = 1'b0;
               key_a     = (addr[BYTE_KEY_W-1:0] == BKEY_A);
               key_b     = (addr[BYTE_KEY_W-1:0] == BKEY_B);
               case (addr[2:0])
                  3'd0:    id_sel = ID_MFR;
                  3'd2:    id_sel = ID_DEV;
                  3'd4:    id_sel = ID_PROT;
                  default: id_sel = ID_NONE;
               endcase
            end
         end
      end else begin : g_word
         logic unused_byte_n;
         assign unused_byte_n = byte_n;
         assign widx      = w_idx;
         assign lane_hi   = 1'b0;
         assign word_mode = 1'b1;
         assign key_a     = w_ka;
         assign key_b     = w_kb;
         assign id_sel    = w_id;
      end
   endgenerate

endmodule

// File: rtl/nfc_busy_timer.sv
module nfc_busy_timer #(
   parameter int PROG_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   output logic done
);

   generate
      if (PROG_CYC == 1) begin : g_single
         logic unused_tmr;
         assign unused_tmr = clk ^ rst_n;
         assign done       = busy;
      end else begin : g_count
         localparam int CW = $clog2(PROG_CYC);
         localparam logic [CW-1:0] LAST = CW'(PROG_CYC - 1);
         logic [CW-1:0] cnt_q;

         assign done = busy && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!busy) begin
               cnt_q <= '0;
            end else if (!done) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
   import nfc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] cmd,
   input  logic       key_a,
   input  logic       key_b,
   input  logic       tmr_done,
   input  logic       pend_fail,
   output nfc_state_e st,
   output logic       prog_go,
   output logic       commit
);

   nfc_state_e st_q;
   nfc_state_e st_d;

   assign st     = st_q;
   assign commit = (st_q == ST_BUSY) && tmr_done;

   always_comb begin
      st_d    = st_q;
      prog_go = 1'b0;
      if (wr_en) begin
         case (st_q)
            ST_READ: st_d = (key_a && cmd == KEY_FIRST) ? ST_UNL1 : ST_READ;
            ST_UNL1: st_d = (key_b && cmd == KEY_SECOND) ? ST_UNL2 : ST_READ;
            ST_UNL2: begin
               if (key_a && cmd == OP_IDENT)     st_d = ST_AUTO;
               else if (key_a && cmd == OP_PROG) st_d = ST_PSET;
               else                              st_d = ST_READ;
            end
            ST_AUTO: if (cmd == OP_RESET) st_d = ST_READ;
            ST_PSET: begin
               st_d    = ST_BUSY;
               prog_go = 1'b1;
            end
            ST_BUSY: st_d = ST_BUSY;
            ST_ERR:  if (cmd == OP_RESET) st_d = ST_READ;
            default: st_d = ST_READ;
         endcase
      end
      if (commit) begin
         st_d = pend_fail ? ST_ERR : ST_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_READ;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
   parameter int DEPTH = 256,
   parameter int DW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_word,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_and
);

   logic [DW-1:0] mem_q [DEPTH];

   assign rd_word = mem_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      end else if (wr_en) begin
         mem_q[wr_idx] <= mem_q[wr_idx] & wr_and;
      end
   end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
   import nfc_pkg::*;
#(
   parameter int                AW        = 12,
   parameter int                DEPTH     = 256,
   parameter int                NSECT     = 4,
   parameter logic [NSECT-1:0]  PROT_MAP  = 4'b0100,
   parameter int                PROG_CYC  = 16,
   parameter logic [15:0]       MFR_CODE  = 16'h00C2,
   parameter logic [15:0]       DEV_CODE  = 16'h22A7,
   parameter bit                BYTE_OK   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [15:0]   wdata,
   input  logic          byte_n,
   output logic [15:0]   rdata,
   output logic          ready_o
);

   localparam int IDX_W  = $clog2(DEPTH);
   localparam int SECT_W = $clog2(NSECT);

   generate
      if ((1 << IDX_W) != DEPTH || DEPTH < 16) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 16");
      end
      if ((1 << SECT_W) != NSECT || NSECT < 2 || NSECT > DEPTH / 4) begin : g_bad_sect
         $error("NSECT must be a power of two between 2 and DEPTH/4");
      end
      if (AW < BYTE_KEY_W || AW < IDX_W + 1) begin : g_bad_aw
         $error("AW too narrow for keys or array index");
      end
      if (PROG_CYC < 1) begin : g_bad_cyc
         $error("PROG_CYC must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0]  widx;
   logic              lane_hi;
   logic              word_mode;
   logic              key_a;
   logic              key_b;
   nfc_id_e           id_sel;
   nfc_state_e        st_q;
   logic              prog_go;
   logic              commit;
   logic              tmr_done;
   logic [DATA_W-1:0] rd_word;

   logic [IDX_W-1:0]  p_idx_q;
   logic [DATA_W-1:0] p_and_q;
   logic              p_fail_q;
   logic              p_b7_q;
   logic              tog_q;
   logic [DATA_W-1:0] rdata_q;

   nfc_addr_map #(.AW(AW), .IDX_W(IDX_W), .BYTE_OK(BYTE_OK)) u_map (
      .addr      (addr),
      .byte_n    (byte_n),
      .widx      (widx),
      .lane_hi   (lane_hi),
      .word_mode (word_mode),
      .key_a     (key_a),
      .key_b     (key_b),
      .id_sel    (id_sel)
   );

   nfc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .cmd       (wdata[7:0]),
      .key_a     (key_a),
      .key_b     (key_b),
      .tmr_done  (tmr_done),
      .pend_fail (p_fail_q),
      .st        (st_q),
      .prog_go   (prog_go),
      .commit    (commit)
   );

   nfc_busy_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (st_q == ST_BUSY),
      .done  (tmr_done)
   );

   nfc_array #(.DEPTH(DEPTH), .DW(DATA_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (widx),
      .rd_word (rd_word),
      .wr_en   (commit),
      .wr_idx  (p_idx_q),
      .wr_and  (p_and_q)
   );

   // Program data placed on its lane: bits requested as 1, and AND mask.
   logic [DATA_W-1:0] want_ones;
   logic [DATA_W-1:0] and_mask;
   always_comb begin
      if (word_mode) begin
         want_ones = wdata;
         and_mask  = wdata;
      end else if (lane_hi) begin
         want_ones = {wdata[7:0], 8'h00};
         and_mask  = {wdata[7:0], 8'hFF};
      end else begin
         want_ones = {8'h00, wdata[7:0]};
         and_mask  = {8'hFF, wdata[7:0]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_idx_q  <= '0;
         p_and_q  <= '1;
         p_fail_q <= 1'b0;
         p_b7_q   <= 1'b0;
      end else if (prog_go) begin
         p_idx_q  <= widx;
         p_and_q  <= and_mask;
         p_fail_q <= |(want_ones & ~rd_word);
         p_b7_q   <= wdata[7];
      end
   end

   logic status_mode;
   assign status_mode = (st_q == ST_BUSY) || (st_q == ST_ERR);
   assign ready_o     = !status_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     tog_q <= 1'b0;
      else if (prog_go)               tog_q <= 1'b0;
      else if (rd_en && status_mode)  tog_q <= ~tog_q;
   end

   logic [DATA_W-1:0] id_word;
   logic              prot_bit;
   assign prot_bit = PROT_MAP[widx[IDX_W-1 -: SECT_W]];

   always_comb begin
      case (id_sel)
         ID_MFR:  id_word = MFR_CODE;
         ID_DEV:  id_word = DEV_CODE;
         ID_PROT: id_word = {15'd0, prot_bit};
         default: id_word = '0;
      endcase
      if (!word_mode) id_word = {8'h00, id_word[7:0]};
   end

   logic [DATA_W-1:0] arr_view;
   assign arr_view = word_mode ? rd_word
                   : {8'h00, (lane_hi ? rd_word[15:8] : rd_word[7:0])};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         if (status_mode)          rdata_q <= {8'h00, ~p_b7_q, tog_q, p_fail_q, 5'd0};
         else if (st_q == ST_AUTO) rdata_q <= id_word;
         else                      rdata_q <= arr_view;
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/nor_cmd_engine_chk.sv
module nor_cmd_engine_chk
   import nfc_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        rd_en,
   input logic [15:0] wdata,
   input logic [15:0] rdata,
   input logic        ready_o,
   input nfc_state_e  st,
   input logic        tmr_done
);

   // R2: result changes only on a read strobe
   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R3: wrong second unlock cycle falls back to reading
   a_r3_bad_second: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_UNL1 && wr_en && wdata[7:0] != 8'h55) |=> st == ST_READ);

   // R5: identification mode persists until a reset write
   a_r5_ident_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AUTO && !(wr_en && wdata[7:0] == 8'hF0)) |=> st == ST_AUTO);

   // R8: fourth program cycle drops ready
   a_r8_fourth_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PSET && wr_en) |=> (st == ST_BUSY && !ready_o));

   // R9: unused status bits stay zero
   a_r9_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && st == ST_BUSY) |=> (rdata[15:8] == 8'h00 && rdata[4:0] == 5'd0));

   // R10: busy survives every write until the timer ends it
   a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BUSY && !tmr_done) |=> (st == ST_BUSY && !ready_o));

   // R11: error state is sticky until a reset write
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERR && !(wr_en && wdata[7:0] == 8'hF0)) |=> (st == ST_ERR && !ready_o));

endmodule

bind nor_cmd_engine nor_cmd_engine_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .wdata    (wdata),
   .rdata    (rdata),
   .ready_o  (ready_o),
   .st       (st_q),
   .tmr_done (tmr_done)
);

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb;

   localparam int PROG_CYC = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [15:0] wdata = '0;
   logic        byte_n = 1'b1;
   logic [15:0] rdata;
   logic        ready_o;

   always #10 clk = ~clk;

   nor_cmd_engine #(
      .AW(12), .DEPTH(256), .NSECT(4), .PROT_MAP(4'b0100), .PROG_CYC(PROG_CYC),
      .MFR_CODE(16'h00C2), .DEV_CODE(16'h22A7), .BYTE_OK(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .byte_n(byte_n), .rdata(rdata), .ready_o(ready_o)
   );

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_vec = 0;
   int n_bad = 0;
   logic rd_seen = 1'b0;

   function automatic void chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endfunction

   // monitor: compares each read result after its clock edge
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_q.size() == 0) begin
            chk("scoreboard underflow", 16'h0, 16'h1);
         end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, rdata, it.exp);
         end
      end
   end

   task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      sb_q.push_back('{exp: exp, tag: tag});
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ready_o && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic prog_word(input logic [11:0] a, input logic [15:0] d);
      bus_wr(12'h555, 16'h00AA);
      bus_wr(12'h2AA, 16'h0055);
      bus_wr(12'h555, 16'h00A0);
      bus_wr(a, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ready after reset", 16'(ready_o), 16'h1);
      bus_rd(12'h010, 16'hFFFF, "R1 erased word");

      // R8 program, busy length, AND result
      prog_word(12'h010, 16'h12F0);
      chk("R8 ready low after fourth cycle", 16'(ready_o), 16'h0);
      wait_ready(n);
      chk("R8 busy cycles", 16'(n), 16'(PROG_CYC));
      bus_rd(12'h010, 16'h12F0, "R8 programmed word");
      prog_word(12'h010, 16'h1230);
      wait_ready(n);
      bus_rd(12'h010, 16'h1230, "R8 second program clears bits");

      // R9 status and R10 writes ignored while busy
      prog_word(12'h020, 16'h0055);
      bus_rd(12'h000, 16'h0080, "R9 status first read");
      bus_rd(12'h020, 16'h00C0, "R9 status toggled");
      bus_rd(12'h020, 16'h0080, "R9 status toggled back");
      bus_wr(12'h000, 16'h00F0);
      chk("R10 reset ignored while busy", 16'(ready_o), 16'h0);
      bus_rd(12'h020, 16'h00C0, "R10 still status after reset write");
      wait_ready(n);
      bus_rd(12'h020, 16'h0055, "R8 word after status phase");

      // R11 failing program
      prog_word(12'h020, 16'h00AA);
      bus_rd(12'h020, 16'h0020, "R11 fail flag in status");
      bus_rd(12'h020, 16'h0060, "R11 fail status toggled");
      repeat (PROG_CYC + 4) @(negedge clk);
      chk("R11 ready stays low after fail", 16'(ready_o), 16'h0);
      bus_wr(12'h555, 16'h00AA);
      chk("R11 non-reset write ignored in error", 16'(ready_o), 16'h0);
      bus_rd(12'h020, 16'h0020, "R11 status persists");
      bus_wr(12'h3C3, 16'h00F0);
      chk("R11 reset clears error", 16'(ready_o), 16'h1);
      bus_rd(12'h020, 16'h0000, "R11 stored AND after fail");

      // R3 wrong data and wrong address
      bus_wr(12'h555, 16'h00AA);
      bus_wr(12'h2AA, 16'h0056);
      bus_wr(12'h555, 16'h00A0);
      bus_wr(12'h030, 16'h0000);
      chk("R3 no program after bad data", 16'(ready_o), 16'h1);
      bus_rd(12'h030, 16'hFFFF, "R3 word untouched");
      bus_wr(12'h555, 16'h00AA);
      bus_wr(12'h2AB, 16'h0055);
      bus_wr(12'h555, 16'h0090);
      bus_rd(12'h000, 16'hFFFF, "R3 bad address stays in read");

      // R4 reset between unlock cycles
      bus_wr(12'h555, 16'h00AA);
      bus_wr(12'h123, 16'h00F0);
      bus_wr(12'h2AA, 16'h0055);
      bus_wr(12'h555, 16'h00A0);
      bus_wr(12'h040, 16'h0000);
      chk("R4 reset aborted sequence", 16'(ready_o), 16'h1);
      bus_rd(12'h040, 16'hFFFF, "R4 word untouched");

      // R5 R6 R7 identification, word mode
      bus_wr(12'h555, 16'h00AA);
      bus_wr(12'h2AA, 16'h0055);
      bus_wr(12'h555, 16'h0090);
      bus_rd(12'h000, 16'h00C2, "R6 maker code word");
      bus_rd(12'h001, 16'h22A7, "R6 device code word");
      bus_rd(12'h002, 16'h0000, "R7 sector 0 unprotected");
      bus_rd(12'h082, 16'h0001, "R7 sector 2 protected");
      bus_rd(12'h003, 16'h0000, "R6 unused offset");
      bus_wr(12'h555, 16'h00AA);
      bus_rd(12'h000, 16'h00C2, "R5 mode persists");
      bus_wr(12'h000, 16'h00F0);
      bus_rd(12'h000, 16'hFFFF, "R4 reset leaves identification");

      // R12 byte mode
      @(negedge clk);
      byte_n = 1'b0;
      bus_wr(12'hAAA, 16'h00AA);
      bus_wr(12'h555, 16'h0055);
      bus_wr(12'hAAA, 16'h0090);
      bus_rd(12'h000, 16'h00C2, "R6 maker code byte");
      bus_rd(12'h002, 16'h00A7, "R6 device code byte");
      bus_rd(12'h004, 16'h0000, "R7 sector 0 byte");
      bus_rd(12'h104, 16'h0001, "R7 sector 2 byte");
      bus_wr(12'h000, 16'h00F0);
      bus_wr(12'hAAA, 16'h00AA);
      bus_wr(12'h555, 16'h0055);
      bus_wr(12'hAAA, 16'h00A0);
      bus_wr(12'h061, 16'h003C);
      wait_ready(n);
      chk("R12 byte program busy cycles", 16'(n), 16'(PROG_CYC));
      bus_rd(12'h060, 16'h00FF, "R12 low lane untouched");
      bus_rd(12'h061, 16'h003C, "R12 high lane programmed");
      @(negedge clk);
      byte_n = 1'b1;
      bus_rd(12'h030, 16'h3CFF, "R2 word view of byte program");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) chk("scoreboard drained", 16'(sb_q.size()), 16'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule